// File: doc/BRIEF.md
# Clock Generator Reconfiguration Sequencer

This block reprograms a clock-synthesis primitive through its dynamic reconfiguration port. A start pulse holds the primitive in reset and runs a fixed, ordered list of eleven 16-bit register writes. For each write the block presents the address and data, raises the enable for one cycle, and then waits for the port's ready handshake. After the last write it releases reset and waits a lock-settling interval. It then samples the lock flag and reports done together with a pass, lock-failure or timeout status.

The eleven setting words come in on one flat input vector. They must be stable before the start pulse and stay stable while the block is busy. Outside a sequence, a host can make single register reads and writes on a request/response pair. The request side uses valid/ready: a request is taken on a clock edge where `host_valid` and `host_ready` are both high. `host_ready` is low whenever a sequence or an earlier host access is in progress, and in any cycle where `start` is high.

The response side also uses valid/ready. `rsp_valid` stays high, with `rsp_data` and `rsp_err` unchanged, until a clock edge where `rsp_ready` is high. No new request is accepted until that response has been taken. Every wait for ready on the port is bounded by a watchdog, so a primitive that never answers ends the access with an error instead of hanging the block.

Top module: `clkcfg_sequencer`

## Requirements
- R1: Each port access drives `port_en` high for exactly one cycle, with `port_addr` valid in that cycle. For a write, `port_di` and `port_we` are also driven in that cycle. `port_we` is never high without `port_en`.
- R2: After the enable cycle, `port_en` and `port_we` stay low until `port_rdy` is seen high. Only one access is in flight at a time.
- R3: A host read (`host_write`=0) returns `port_do`, sampled in the cycle `port_rdy` is high, on `rsp_data` with `rsp_err`=0. `rsp_valid`, `rsp_data` and `rsp_err` stay unchanged until `rsp_ready` is high.
- R4: A host write (`host_write`=1) performs one port write of `host_wdata` to `host_addr`. It is answered by one response with `rsp_err`=0.
- R5: A `start` pulse seen while idle runs eleven port writes, to addresses 0x08, 0x09, 0x14, 0x15, 0x16, 0x18, 0x19, 0x1A, 0x28, 0x4E, 0x4F in that order. Write k (k = 0 to 10) carries `cfg_words[16k+15:16k]`.
- R6: `prim_rst` rises in the cycle after the accepted start and is high during every enable cycle of the sequence. It falls only after the ready of the eleventh write.
- R7: `done` becomes visible exactly LOCK_CYCLES = CLK_MHZ*LOCK_US cycles after the first cycle with `prim_rst` low. `pass` equals `prim_locked` as it was in the last of those cycles.
- R8: `done` is a one-cycle pulse. Status encoding: `pass`=1, `timeout`=0 means success; `pass`=0, `timeout`=0 means lock failure; `pass`=0, `timeout`=1 means ready timeout. The status is held until the next accepted start and is never `pass`=1 together with `timeout`=1.
- R9: `busy` is high from the cycle after the accepted start until the cycle in which `done` is high, when it is low. A `start` pulse while busy is ignored, and `host_ready` is low while busy.
- R10: If `port_rdy` is not seen within RDY_TIMEOUT cycles after an enable cycle, a sequence aborts with `done` and `timeout`=1 and leaves `prim_rst` high. A host access in the same situation answers with `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for the reconfiguration sequence |
| cfg_words | input | 176 | Eleven setting words; word k at bits 16k+15:16k |
| prim_locked | input | 1 | Lock flag from the primitive |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted when high with valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 16 | Host write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_data | output | 16 | Read data |
| rsp_err | output | 1 | Response ended by ready timeout |
| port_addr | output | 8 | Port address |
| port_di | output | 16 | Port write data |
| port_en | output | 1 | Port enable, one cycle per access |
| port_we | output | 1 | Port write enable |
| port_do | input | 16 | Port read data |
| port_rdy | input | 1 | Port ready handshake |
| prim_rst | output | 1 | Reset to the primitive |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle sequence completion pulse |
| pass | output | 1 | Sequence succeeded with lock |
| timeout | output | 1 | Sequence aborted on ready timeout |

## Verification
The assertions assume that `port_rdy` comes at most once per enable, and no earlier than the cycle after it. They also assume that `cfg_words` does not change while `busy` is high; `start`, `host_valid` and `rsp_ready` may arrive in any cycle. The bench's responder keeps to this: it answers each enable exactly once after a latency of one or more cycles, or not at all when muted. The bench changes the setting words only between sequences. It drives start and host requests at arbitrary points, including a start in the middle of a sequence and a response held back for several cycles.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NUM_REGS = 11;
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [2:0] {
    S_IDLE, S_CFG_REQ, S_CFG_WAIT, S_LOCK, S_HOST_WAIT, S_HOST_RSP
  } seq_state_t;

  typedef enum logic [1:0] {E_IDLE, E_EN, E_WAIT} eng_state_t;

  // Fixed write order; the primitive decodes these addresses.
  function automatic logic [7:0] reg_addr(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    reg_addr = 8'h08;
      4'd1:    reg_addr = 8'h09;
      4'd2:    reg_addr = 8'h14;
      4'd3:    reg_addr = 8'h15;
      4'd4:    reg_addr = 8'h16;
      4'd5:    reg_addr = 8'h18;
      4'd6:    reg_addr = 8'h19;
      4'd7:    reg_addr = 8'h1A;
      4'd8:    reg_addr = 8'h28;
      4'd9:    reg_addr = 8'h4E;
      4'd10:   reg_addr = 8'h4F;
      default: reg_addr = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_port_engine.sv
module clkcfg_port_engine #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int TMO = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_di,
  output logic          port_en,
  output logic          port_we,
  input  logic [DW-1:0] port_do,
  input  logic          port_rdy,
  output logic          ack,
  output logic          ack_ok,
  output logic [DW-1:0] ack_data
);
  import clkcfg_pkg::*;
  localparam int CW = $clog2(TMO + 1);

  eng_state_t    st;
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= E_IDLE;
      wait_cnt <= '0;
      port_addr <= '0;
      port_di <= '0;
      port_en <= 1'b0;
      port_we <= 1'b0;
      ack <= 1'b0;
      ack_ok <= 1'b0;
      ack_data <= '0;
    end else begin
      ack <= 1'b0;
      port_en <= 1'b0;
      port_we <= 1'b0;
      case (st)
        E_IDLE: if (req) begin
          port_addr <= req_addr;
          port_di <= req_data;
          port_en <= 1'b1;
          port_we <= req_we;
          st <= E_EN;
        end
        E_EN: begin
          wait_cnt <= '0;
          st <= E_WAIT;
        end
        E_WAIT: begin
          if (port_rdy) begin
            ack <= 1'b1;
            ack_ok <= 1'b1;
            ack_data <= port_do;
            st <= E_IDLE;
          end else if (wait_cnt == CW'(TMO - 1)) begin
            ack <= 1'b1;
            ack_ok <= 1'b0;
            st <= E_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkcfg_lock_timer.sv
module clkcfg_lock_timer #(
  parameter int CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] cnt;
  logic          run;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= TW'(CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/clkcfg_sequencer.sv
module clkcfg_sequencer #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int CLK_MHZ     = 125,
  parameter int LOCK_US     = 100,
  parameter int RDY_TIMEOUT = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [clkcfg_pkg::NUM_REGS*DW-1:0] cfg_words,
  input  logic                           prim_locked,
  input  logic                           host_valid,
  output logic                           host_ready,
  input  logic                           host_write,
  input  logic [AW-1:0]                  host_addr,
  input  logic [DW-1:0]                  host_wdata,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [DW-1:0]                  rsp_data,
  output logic                           rsp_err,
  output logic [AW-1:0]                  port_addr,
  output logic [DW-1:0]                  port_di,
  output logic                           port_en,
  output logic                           port_we,
  input  logic [DW-1:0]                  port_do,
  input  logic                           port_rdy,
  output logic                           prim_rst,
  output logic                           busy,
  output logic                           done,
  output logic                           pass,
  output logic                           timeout
);
  import clkcfg_pkg::*;
  localparam int LOCK_CYCLES = CLK_MHZ * LOCK_US;

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic             req, req_we;
  logic [AW-1:0]    req_addr;
  logic [DW-1:0]    req_data;
  logic             ack, ack_ok;
  logic [DW-1:0]    ack_data;
  logic             last_ok, lock_load, lock_expire;

  assign host_ready = (state == S_IDLE) && !start;
  assign busy       = (state == S_CFG_REQ) || (state == S_CFG_WAIT) || (state == S_LOCK);
  assign last_ok    = ack && ack_ok && (idx == IDX_W'(NUM_REGS - 1));
  assign lock_load  = (state == S_CFG_WAIT) && last_ok;

  always_comb begin
    if (state == S_CFG_REQ) begin
      req      = 1'b1;
      req_we   = 1'b1;
      req_addr = AW'(reg_addr(idx));
      req_data = cfg_words[idx*DW +: DW];
    end else begin
      req      = host_valid && host_ready;
      req_we   = host_write;
      req_addr = host_addr;
      req_data = host_wdata;
    end
  end

  clkcfg_port_engine #(.AW(AW), .DW(DW), .TMO(RDY_TIMEOUT)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_data(req_data),
    .port_addr(port_addr), .port_di(port_di), .port_en(port_en), .port_we(port_we),
    .port_do(port_do), .port_rdy(port_rdy),
    .ack(ack), .ack_ok(ack_ok), .ack_data(ack_data)
  );

  clkcfg_lock_timer #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(lock_load), .expire(lock_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx <= '0;
      prim_rst <= 1'b0;
      done <= 1'b0;
      pass <= 1'b0;
      timeout <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
      rsp_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            prim_rst <= 1'b1;
            pass <= 1'b0;
            timeout <= 1'b0;
            idx <= '0;
            state <= S_CFG_REQ;
          end else if (host_valid) begin
            state <= S_HOST_WAIT;
          end
        end
        S_CFG_REQ: state <= S_CFG_WAIT;
        S_CFG_WAIT: if (ack) begin
          if (!ack_ok) begin
            timeout <= 1'b1;
            done <= 1'b1;
            state <= S_IDLE;
          end else if (last_ok) begin
            prim_rst <= 1'b0;
            state <= S_LOCK;
          end else begin
            idx <= idx + 1'b1;
            state <= S_CFG_REQ;
          end
        end
        S_LOCK: if (lock_expire) begin
          pass <= prim_locked;
          done <= 1'b1;
          state <= S_IDLE;
        end
        S_HOST_WAIT: if (ack) begin
          rsp_valid <= 1'b1;
          rsp_data <= ack_data;
          rsp_err <= !ack_ok;
          state <= S_HOST_RSP;
        end
        S_HOST_RSP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkcfg_sequencer_chk.sv
module clkcfg_sequencer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          port_we,
  input logic          prim_rst,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          timeout,
  input logic          host_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_err
);
  AST_EN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) port_en |=> !port_en); // R1
  AST_WE_ONLY_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n) port_we |-> port_en); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err))); // R3
  AST_RST_DURING_CFG: assert property (@(posedge clk) disable iff (!rst_n) (busy && port_en) |-> prim_rst); // R6
  AST_RST_RELEASE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n) $fell(prim_rst) |-> (busy && !port_en)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !(pass && timeout)); // R8
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_NO_HOST_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !host_ready); // R9
  AST_TIMEOUT_KEEPS_RST: assert property (@(posedge clk) disable iff (!rst_n) (done && timeout) |-> prim_rst); // R10
endmodule

bind clkcfg_sequencer clkcfg_sequencer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_we(port_we),
  .prim_rst(prim_rst), .busy(busy), .done(done), .pass(pass), .timeout(timeout),
  .host_ready(host_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_err(rsp_err)
);

// File: tb/clkcfg_sequencer_test.sv
`timescale 1ns/1ps
module clkcfg_sequencer_test;
  localparam int NREG = 11;
  localparam int TMO  = 64;
  localparam int LOCK_CYCLES = 125 * 100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, prim_locked = 1'b0;
  logic [NREG*16-1:0] cfg_words = '0;
  logic host_valid = 1'b0, host_write = 1'b0, rsp_ready = 1'b0;
  logic [7:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic host_ready, rsp_valid, rsp_err, port_en, port_we, prim_rst, busy, done, pass, timeout;
  logic [15:0] rsp_data, port_di;
  logic [7:0] port_addr;
  logic [15:0] port_do;
  logic port_rdy;

  always #4 clk = ~clk;

  clkcfg_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_words(cfg_words), .prim_locked(prim_locked),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .port_addr(port_addr), .port_di(port_di), .port_en(port_en), .port_we(port_we),
    .port_do(port_do), .port_rdy(port_rdy), .prim_rst(prim_rst), .busy(busy),
    .done(done), .pass(pass), .timeout(timeout)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural register-file responder with programmable ready latency.
  logic [15:0] mem [256];
  int lat = 1;
  bit mute = 1'b0;
  bit pend = 1'b0;
  int lcnt = 0;
  logic [7:0] p_a;
  logic [15:0] p_d;
  logic p_w;
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      port_rdy <= 1'b0;
      port_do <= '0;
    end else begin
      port_rdy <= 1'b0;
      if (pend) begin
        if (lcnt == 0) begin
          port_rdy <= 1'b1;
          port_do <= mem[p_a];
          if (p_w) mem[p_a] <= p_d;
          pend <= 1'b0;
        end else lcnt <= lcnt - 1;
      end
      if (port_en && !mute) begin
        pend <= 1'b1;
        lcnt <= lat - 1;
        p_a <= port_addr;
        p_d <= port_di;
        p_w <= port_we;
      end
    end
  end

  // Reference expectations for port accesses, compared on every clock.
  logic [7:0]  q_addr[$];
  logic [15:0] q_data[$];
  bit          q_we[$];
  bit          q_seq[$];
  int done_count = 0;
  bit prev_rst = 1'b0, lk_run = 1'b0, prev_done = 1'b0;
  int lk_n = 0;

  function automatic logic [7:0] exp_addr(input int k);
    logic [7:0] t [NREG] = '{8'h08, 8'h09, 8'h14, 8'h15, 8'h16, 8'h18, 8'h19, 8'h1A, 8'h28, 8'h4E, 8'h4F};
    return t[k];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (port_en) begin
        chk(!pend, "R2", "enable while access in flight", pend, 0);
        if (q_addr.size() == 0) begin
          chk(1'b0, "R5", "unexpected port access", port_addr, 0);
        end else begin
          automatic logic [7:0] ea = q_addr.pop_front();
          automatic logic [15:0] ed = q_data.pop_front();
          automatic bit ew = q_we.pop_front();
          automatic bit es = q_seq.pop_front();
          chk(port_addr == ea, "R5", "port address", port_addr, ea);
          chk(port_we == ew, "R1", "write enable", port_we, ew);
          if (ew) chk(port_di == ed, "R5", "write data", port_di, ed);
          if (es) chk(prim_rst == 1'b1, "R6", "reset during write", prim_rst, 1);
        end
      end
      if (prev_rst && !prim_rst) begin
        lk_run = 1'b1;
        lk_n = 0;
      end else if (lk_run) begin
        lk_n++;
      end
      if (done) begin
        done_count++;
        chk(!busy, "R9", "busy low with done", busy, 0);
        chk(!prev_done, "R8", "done single pulse", prev_done, 0);
        if (lk_run) begin
          chk(lk_n == LOCK_CYCLES, "R7", "lock wait length", lk_n, LOCK_CYCLES);
          lk_run = 1'b0;
        end
      end
      prev_rst = prim_rst;
      prev_done = done;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic push_seq(input logic [NREG*16-1:0] w);
    for (int k = 0; k < NREG; k++) begin
      q_addr.push_back(exp_addr(k));
      q_data.push_back(w[k*16 +: 16]);
      q_we.push_back(1'b1);
      q_seq.push_back(1'b1);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic host_access(input bit we, input logic [7:0] a, input logic [15:0] d,
                             input int hold, output logic [15:0] rd, output bit err);
    int n = 0;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_write = we; host_addr = a; host_wdata = d;
    q_addr.push_back(a); q_data.push_back(d); q_we.push_back(we); q_seq.push_back(1'b0);
    @(negedge clk) host_valid = 1'b0;
    while (!rsp_valid && n < 500) begin
      @(negedge clk);
      n++;
    end
    rd = rsp_data;
    err = rsp_err;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == rd, "R3", "response held under back-pressure", rsp_data, rd);
    end
    rsp_ready = 1'b1;
    @(negedge clk) rsp_ready = 1'b0;
    chk(!rsp_valid, "R3", "response cleared after accept", rsp_valid, 0);
  endtask

  initial begin
    logic [15:0] rd;
    bit err;
    int n;
    logic [NREG*16-1:0] w1, w2;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
    for (int k = 0; k < NREG; k++) begin
      w1[k*16 +: 16] = 16'hA000 + 16'(k * 16'h0111);
      w2[k*16 +: 16] = w1[k*16 +: 16] ^ 16'h5A5A;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !prim_rst && !port_en && !rsp_valid, "R9", "reset state idle",
        {busy, done, prim_rst, port_en, rsp_valid}, 0);
    chk(host_ready, "R9", "host ready after reset", host_ready, 1);

    // Host write then read back, with varied latency (R4, R3, R2)
    lat = 3;
    host_access(1'b1, 8'h33, 16'hBEEF, 0, rd, err);
    chk(!err, "R4", "write response error flag", err, 0);
    lat = 7;
    host_access(1'b0, 8'h33, 16'h0, 4, rd, err);
    chk(rd == 16'hBEEF && !err, "R3", "read data after write", rd, 16'hBEEF);
    lat = 1;
    host_access(1'b0, 8'h10, 16'h0, 0, rd, err);
    chk(rd == 16'h0030, "R3", "read of untouched register", rd, 16'h0030);

    // Full sequence with lock, plus an ignored mid-sequence start (R5..R9)
    cfg_words = w1; prim_locked = 1'b1; lat = 2;
    push_seq(w1);
    pulse_start();
    chk(busy && prim_rst, "R6", "busy and reset after start", {busy, prim_rst}, 3);
    repeat (10) @(negedge clk);
    chk(!host_ready, "R9", "host blocked while busy", host_ready, 0);
    pulse_start();
    wait_done(n);
    chk(done && pass && !timeout, "R7", "success status", {done, pass, timeout}, 3'b110);
    chk(q_addr.size() == 0, "R5", "all eleven writes issued", q_addr.size(), 0);
    chk(!prim_rst, "R6", "reset released after sequence", prim_rst, 0);
    chk(mem[8'h4F] == w1[10*16 +: 16], "R5", "last register content", mem[8'h4F], w1[10*16 +: 16]);
    repeat (6) @(negedge clk);
    chk(pass && done_count == 1, "R8", "status held, single done", {pass, 8'(done_count)}, 9'h101);

    // Lock failure (R7, R8)
    cfg_words = w2; prim_locked = 1'b0; lat = 4;
    push_seq(w2);
    pulse_start();
    wait_done(n);
    chk(!pass && !timeout, "R8", "lock failure status", {pass, timeout}, 0);
    chk(mem[8'h08] == w2[15:0], "R5", "first register content", mem[8'h08], w2[15:0]);

    // Ready timeout on sequence and on host access (R10)
    mute = 1'b1; prim_locked = 1'b1;
    push_seq(w2);
    pulse_start();
    while (!port_en) @(negedge clk);
    wait_done(n);
    chk(n > TMO && n <= TMO + 3, "R10", "timeout delay", n, TMO + 2);
    chk(timeout && !pass && prim_rst, "R10", "timeout status keeps reset", {timeout, pass, prim_rst}, 3'b101);
    q_addr.delete(); q_data.delete(); q_we.delete(); q_seq.delete();
    host_access(1'b0, 8'h20, 16'h0, 0, rd, err);
    chk(err, "R10", "host access timeout error", err, 1);

    // Recovery after abort (R8)
    mute = 1'b0; lat = 1; cfg_words = w1;
    push_seq(w1);
    pulse_start();
    chk(!timeout, "R8", "status cleared by new start", timeout, 0);
    wait_done(n);
    chk(pass && !timeout && !prim_rst, "R8", "recovered success", {pass, timeout, prim_rst}, 3'b100);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule